// File: doc/BRIEF.md
# Latched Three-Decade BCD Event Counter

This block counts events on an asynchronous count line and shows the total as three binary-coded decimal digits (units, tens, hundreds). The count line is resynchronised to the system clock, and each high-to-low transition adds one to the total. A hold input pauses counting without losing the total. A clear input zeroes the three decades.

Each decade feeds a four-bit holding register. While the capture input is low, the registers track the live count. While it is high, they keep the value they had when it rose. That snapshot survives a clear of the decades, so a reading can be frozen, the counter restarted, and the old value still read. When the total rolls from 999 back to 000, a one-cycle carry pulse is produced, so a second instance can count thousands.

Top module: `bcd_tri_counter`

## Requirements
- R1: Each high-to-low transition of `cnt_i` (held at least two clock cycles in each level) adds exactly one to the count. The decade registers change on the third rising clock edge after the transition is sampled, and `digits_o` shows it one cycle later. A low-to-high transition changes nothing.
- R2: Each decade holds a value from 0 to 9. The units digit is `digits_o[3:0]`, the tens digit `digits_o[7:4]` and the hundreds digit `digits_o[11:8]`. A decade at 9 that receives an increment returns to 0 and passes one increment to the next decade up.
- R3: While `hold_i` is high, count transitions are ignored and the count stays unchanged.
- R4: While `clr_i` is high, all decades are forced to 0 and `carry_o` stays low. A count transition that arrives while `clr_i` is high is discarded, and clear takes priority over counting.
- R5: While `cap_i` is low, `digits_o` follows the decade registers with one cycle of delay.
- R6: While `cap_i` is high, `digits_o` keeps the value it had when `cap_i` rose, whatever the count, hold or clear inputs do.
- R7: If `cap_i` stays high for the whole time `clr_i` is high, the captured value is still on `digits_o` after the clear. It is replaced by 000 once `cap_i` goes low.
- R8: `carry_o` is an active-high pulse one clock cycle wide. It is raised in the cycle in which the count has just wrapped from 999 to 000, and it occurs exactly once per 1000 counted transitions.
- R9: While `rst_n` is low, the decades, the holding registers and `carry_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cnt_i | input | 1 | Asynchronous event line; its falling transitions are counted |
| hold_i | input | 1 | Pauses counting while high |
| clr_i | input | 1 | Synchronous clear of the decades while high |
| cap_i | input | 1 | Freezes the holding registers while high |
| digits_o | output | 12 | Held BCD digits: hundreds, tens, units from high to low |
| carry_o | output | 1 | One-cycle pulse on a wrap from 999 to 000 |

## Verification
The assertions assume that `cnt_i` stays in each level for at least two system clock cycles. At most one increment can then arrive per cycle. They also assume `hold_i`, `clr_i` and `cap_i` are synchronous to `clk`. The stimulus changes every input only on the falling clock edge and holds the count line for three cycles per level. Hold and clear are raised before a pulse begins and released only after the synchroniser has settled. Inputs therefore never change close to the sampling edge, and no increment is left in flight when a control input changes.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_TOP = 9;

    typedef logic [DIGIT_W-1:0] bcd_t;

    function automatic bcd_t bcd_step(input bcd_t v);
        return (v == bcd_t'(DIGIT_TOP)) ? bcd_t'(0) : v + bcd_t'(1);
    endfunction
endpackage

// File: rtl/bcd_fall_detect.sv
module bcd_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], line_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.sync[STAGES-1];

    AST_SINGLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R1
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output bcd_t digit_o,
    output logic at_top_o
);
    typedef struct packed {
        bcd_t digit;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)      st_d.digit = '0;
        else if (inc_i) st_d.digit = bcd_step(st_q.digit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign digit_o  = st_q.digit;
    assign at_top_o = (st_q.digit == bcd_t'(DIGIT_TOP));

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        digit_o <= bcd_t'(DIGIT_TOP)); // R2
    AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top_o && inc_i && !clr_i) |=> digit_o == '0); // R2
    AST_DIGIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> digit_o == '0); // R4
    AST_DIGIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(digit_o)); // R3
endmodule

// File: rtl/bcd_hold_reg.sv
module bcd_hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] held_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cap_i) st_d.val = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.val;

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> $stable(held_o)); // R6
    AST_HOLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> held_o == $past(src_i)); // R5
endmodule

// File: rtl/bcd_tri_counter.sv
module bcd_tri_counter
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cnt_i,
    input  logic                          hold_i,
    input  logic                          clr_i,
    input  logic                          cap_i,
    output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o,
    output logic                          carry_o
);
    localparam int VAL_W = NUM_DIGITS * DIGIT_W;

    typedef struct packed {
        logic carry;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                  fall;
    logic [NUM_DIGITS:0]   inc;
    logic [NUM_DIGITS-1:0] at_top;
    logic [VAL_W-1:0]      live;

    bcd_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (cnt_i),
        .fall_o (fall)
    );

    assign inc[0] = fall & ~hold_i & ~clr_i;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        bcd_decade u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr_i),
            .inc_i    (inc[g]),
            .digit_o  (live[g*DIGIT_W +: DIGIT_W]),
            .at_top_o (at_top[g])
        );
        assign inc[g+1] = inc[g] & at_top[g];
    end

    always_comb begin
        st_d       = st_q;
        st_d.carry = inc[NUM_DIGITS] & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry_o = st_q.carry;

    bcd_hold_reg #(.W(VAL_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_i),
        .src_i  (live),
        .held_o (digits_o)
    );

    AST_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> $stable(live)); // R3
    AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (live == '0 && !carry_o)); // R4
    AST_CARRY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> live == '0); // R8
    AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> !carry_o); // R8
    AST_CAP_THROUGH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && clr_i) |=> $stable(digits_o)); // R7
endmodule

// File: tb/bcd_tri_counter_test.sv
module bcd_tri_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_i = 1'b0;
    logic        hold_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        cap_i = 1'b0;
    logic [11:0] digits_o;
    logic        carry_o;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;
    int carry_hi = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bcd_tri_counter uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .hold_i(hold_i),
        .clr_i(clr_i), .cap_i(cap_i), .digits_o(digits_o), .carry_o(carry_o)
    );

    always @(negedge clk) if (rst_n && carry_o) carry_hi++;

    function automatic logic [11:0] to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) cnt_i = 1'b1;
        repeat (3) @(negedge clk);
        cnt_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse();
        settle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9 digits in reset", 32'(digits_o), 32'h0);
        check("R9 carry in reset", 32'(carry_o), 32'h0);
        rst_n = 1'b1;
        settle();
        check("R9 digits after reset", 32'(digits_o), 32'h0);
    endtask

    task automatic t_basic();
        pulses(7); model += 7;
        check("R1 seven pulses", 32'(digits_o), 32'(to_bcd(model)));
        @(negedge clk) cnt_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 rising edge ignored", 32'(digits_o), 32'(to_bcd(model)));
        cnt_i = 1'b0;
        repeat (6) @(negedge clk);
        model += 1;
        check("R1 falling edge counted", 32'(digits_o), 32'(to_bcd(model)));
    endtask

    task automatic t_carry();
        pulses(10 - model); model = 10;
        check("R2 units to tens carry", 32'(digits_o), 32'(to_bcd(model)));
        pulses(100 - model); model = 100;
        check("R2 tens to hundreds carry", 32'(digits_o), 32'(to_bcd(model)));
    endtask

    task automatic t_hold();
        @(negedge clk) hold_i = 1'b1;
        pulses(5);
        check("R3 paused count kept", 32'(digits_o), 32'(to_bcd(model)));
        @(negedge clk) hold_i = 1'b0;
        pulses(1); model += 1;
        check("R3 counts after pause", 32'(digits_o), 32'(to_bcd(model)));
    endtask

    task automatic t_capture();
        int snap = model;
        @(negedge clk) cap_i = 1'b1;
        pulses(4); model += 4;
        check("R6 frozen while captured", 32'(digits_o), 32'(to_bcd(snap)));
        @(negedge clk) cap_i = 1'b0;
        settle();
        check("R5 follows when released", 32'(digits_o), 32'(to_bcd(model)));
    endtask

    task automatic t_clear();
        int snap = model;
        @(negedge clk) cap_i = 1'b1;
        @(negedge clk) clr_i = 1'b1;
        pulse();
        settle();
        @(negedge clk) clr_i = 1'b0;
        settle();
        check("R7 snapshot survives clear", 32'(digits_o), 32'(to_bcd(snap)));
        @(negedge clk) cap_i = 1'b0;
        settle();
        model = 0;
        check("R4 clear zeroes, edge discarded", 32'(digits_o), 32'(to_bcd(0)));
        check("R4 no carry during clear", 32'(carry_hi), 32'h0);
    endtask

    task automatic t_wrap();
        pulses(999); model = 999;
        check("R8 reached 999", 32'(digits_o), 32'(to_bcd(999)));
        check("R8 no carry before wrap", 32'(carry_hi), 32'h0);
        pulses(1); model = 0;
        check("R8 wrapped to 000", 32'(digits_o), 32'(to_bcd(0)));
        check("R8 one-cycle carry pulse", 32'(carry_hi), 32'h1);
        pulses(5); model = 5;
        check("R8 no extra carry", 32'(carry_hi), 32'h1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_carry();
        t_hold();
        t_capture();
        t_clear();
        t_wrap();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule